// File: doc/BRIEF.md
# Low/Full-Speed Line Transmit Serializer

This block turns a stream of packet bytes into the bit-serial line symbols of a low- or full-speed serial bus port. A packet begins when a byte is offered while the line is idle. The block first sends the synchronisation preamble. It then shifts out each byte with the least significant bit first, applies bit stuffing and encodes the result as level-toggle NRZI on a pair of single-ended line outputs. It closes the packet with two SE0 bit times and one J bit time, and then releases the driver.

One bit time lasts one cycle in which the clock-enable `bitTick` is high. All line outputs are registered and change only on such a cycle. Bytes arrive over a valid/ready handshake. `inReady` is high only in a tick cycle where the next bit slot starts a new byte, so the source is held off while a stuffed bit goes out. A parameter selects the 32-bit high-speed preamble in place of the default 8-bit one. CRC and PID generation belong to the layer above, and the analog driver to the layer below.

Top module: `usb_nrzi_tx`

## Requirements
- R1: While the line is idle and after reset, `lineOe`=0, `txActive`=0 and `inReady`=0, and the line outputs rest at J (`lineDp`=1, `lineDm`=0).
- R2: A tick in idle with `inValid`=1 starts a packet. With the default parameter the first eight bit times read K J K J K J K K on the line. That is seven data 0s followed by a data 1, sent from idle J. With `HS_SYNC`=1 the preamble is 31 zeros and then a one (32 bit times).
- R3: The line encoding is J = (`lineDp`=1, `lineDm`=0), K = (0,1) and SE0 = (0,0). A data 1 keeps the previous level and a data 0 inverts it. The level starts from J at each packet.
- R4: Each byte is sent least significant bit first, and its bits follow straight on from the preamble or from the previous byte.
- R5: After six consecutive data 1s, one extra 0 is sent. The trailing 1 of the preamble counts toward the six, and every 0 sent, stuffed or not, clears the count. This includes a stuffed bit owed after the final byte.
- R6: `inReady` is 1 only in a `bitTick` cycle whose bit slot would start a new byte. It is never 1 while a stuffed bit is owed. A byte is taken on a clock edge where `inValid` and `inReady` are both 1.
- R7: After the byte marked with `inLast` and any owed stuffed bit, the line shows SE0, SE0, J for one bit time each. On the next tick `lineOe` returns to 0.
- R8: If a byte slot opens while `inValid`=0 and no `inLast` byte has been taken, the packet is closed at once with the SE0, SE0, J sequence.
- R9: `txActive` equals `lineOe`. It is high from the first preamble bit time through the final J bit time.
- R10: In a cycle with `bitTick`=0, the line outputs keep their values at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | Clock enable, one bit time per high cycle |
| inData | input | 8 | Packet byte |
| inValid | input | 1 | `inData` holds a byte |
| inLast | input | 1 | The offered byte is the final one of the packet |
| inReady | output | 1 | Byte accepted at this edge if valid |
| lineDp | output | 1 | Positive line level |
| lineDm | output | 1 | Negative line level |
| lineOe | output | 1 | Line driver enable |
| txActive | output | 1 | Packet in progress |

## Verification
The byte 0x00 yields a toggle on every bit, which shows the NRZI polarity and the preamble-to-data seam. Runs of 0xFF show repeated stuffing, with `inReady` held low while each stuffed bit goes out. 0x1F shows that the preamble's trailing 1 counts toward the run of six. 0xFC shows that a stuffed bit owed after the final byte comes before the SE0 pair. A sparse `bitTick` pattern checks that outputs hold between ticks. A source that stops without `inLast` checks the early end of packet. Every cycle is compared against a symbol queue that the bench builds from the byte list.

// File: rtl/usb_ser_pkg.sv
package usb_ser_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA, ST_EOP} txState_t;

  typedef struct packed {
    logic syncEn;
    logic syncVal;
    logic stuffEn;
    logic shiftEn;
    logic loadEn;
    logic se0En;
    logic jEn;
    logic releaseEn;
  } txStrobe_t;
endpackage

// File: rtl/usb_ser_ctrl.sv
module usb_ser_ctrl
  import usb_ser_pkg::*;
#(
  parameter int SYNC_LEN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      inValid,
  input  logic      onesFull,
  input  logic      slotEmpty,
  input  logic      lastSeen,
  output txStrobe_t strobe,
  output logic      inReady,
  output logic      txActive
);
  localparam int SYNC_W = $clog2(SYNC_LEN);

  txState_t          state, stateNext;
  logic [SYNC_W-1:0] syncCnt, syncNext;
  logic [1:0]        eopCnt, eopNext;

  assign inReady  = bitTick && (state == ST_DATA) && !onesFull && slotEmpty && !lastSeen;
  assign txActive = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    syncNext  = syncCnt;
    eopNext   = eopCnt;
    if (bitTick) begin
      unique case (state)
        ST_IDLE: if (inValid) begin
          strobe.syncEn = 1'b1;
          syncNext      = SYNC_W'(1);
          stateNext     = ST_SYNC;
        end
        ST_SYNC: begin
          strobe.syncEn  = 1'b1;
          strobe.syncVal = (syncCnt == SYNC_W'(SYNC_LEN - 1));
          syncNext       = syncCnt + SYNC_W'(1);
          if (strobe.syncVal) stateNext = ST_DATA;
        end
        ST_DATA: begin
          if (onesFull)                 strobe.stuffEn = 1'b1;
          else if (!slotEmpty)          strobe.shiftEn = 1'b1;
          else if (inReady && inValid)  strobe.loadEn  = 1'b1;
          else begin
            strobe.se0En = 1'b1;
            eopNext      = 2'd1;
            stateNext    = ST_EOP;
          end
        end
        ST_EOP: begin
          if (eopCnt == 2'd1) begin
            strobe.se0En = 1'b1;
            eopNext      = 2'd2;
          end else if (eopCnt == 2'd2) begin
            strobe.jEn = 1'b1;
            eopNext    = 2'd3;
          end else begin
            strobe.releaseEn = 1'b1;
            eopNext          = 2'd0;
            stateNext        = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      syncCnt <= '0;
      eopCnt  <= '0;
    end else begin
      state   <= stateNext;
      syncCnt <= syncNext;
      eopCnt  <= eopNext;
    end
  end
endmodule

// File: rtl/usb_ser_dp.sv
module usb_ser_dp
  import usb_ser_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              onesFull,
  output logic              slotEmpty,
  output logic              lastSeen,
  output logic              lineDp,
  output logic              lineDm,
  output logic              lineOe
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [ONES_W-1:0] onesCnt;
  logic              level;
  logic              bitOut, anyBit, nextLevel;

  assign onesFull  = (onesCnt == ONES_W'(STUFF_RUN));
  assign slotEmpty = (bitsLeft == '0);

  always_comb begin
    anyBit = strobe.syncEn | strobe.stuffEn | strobe.shiftEn | strobe.loadEn;
    if (strobe.syncEn)       bitOut = strobe.syncVal;
    else if (strobe.stuffEn) bitOut = 1'b0;
    else if (strobe.shiftEn) bitOut = shiftReg[0];
    else                     bitOut = inData[0];
    nextLevel = bitOut ? level : ~level;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      onesCnt  <= '0;
      lastSeen <= 1'b0;
      level    <= 1'b1;
      lineDp   <= 1'b1;
      lineDm   <= 1'b0;
      lineOe   <= 1'b0;
    end else begin
      if (anyBit) begin
        level   <= nextLevel;
        lineDp  <= nextLevel;
        lineDm  <= ~nextLevel;
        lineOe  <= 1'b1;
        onesCnt <= bitOut ? onesCnt + ONES_W'(1) : '0;
      end
      if (strobe.shiftEn) begin
        shiftReg <= shiftReg >> 1;
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
      if (strobe.loadEn) begin
        shiftReg <= inData >> 1;
        bitsLeft <= CNT_W'(DATA_W - 1);
        lastSeen <= inLast;
      end
      if (strobe.se0En) begin
        lineDp <= 1'b0;
        lineDm <= 1'b0;
        lineOe <= 1'b1;
      end
      if (strobe.jEn) begin
        lineDp <= 1'b1;
        lineDm <= 1'b0;
      end
      if (strobe.releaseEn) begin
        lineOe   <= 1'b0;
        level    <= 1'b1;
        onesCnt  <= '0;
        lastSeen <= 1'b0;
        bitsLeft <= '0;
      end
    end
  end
endmodule

// File: rtl/usb_nrzi_tx.sv
module usb_nrzi_tx
  import usb_ser_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter bit HS_SYNC   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              lineDp,
  output logic              lineDm,
  output logic              lineOe,
  output logic              txActive
);
  localparam int SYNC_LEN = HS_SYNC ? 32 : 8;

  txStrobe_t strobe;
  logic      onesFull, slotEmpty, lastSeen;

  usb_ser_ctrl #(.SYNC_LEN(SYNC_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .inValid(inValid),
    .onesFull(onesFull), .slotEmpty(slotEmpty), .lastSeen(lastSeen),
    .strobe(strobe), .inReady(inReady), .txActive(txActive)
  );

  usb_ser_dp #(.DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inLast(inLast),
    .onesFull(onesFull), .slotEmpty(slotEmpty), .lastSeen(lastSeen),
    .lineDp(lineDp), .lineDm(lineDm), .lineOe(lineOe)
  );
endmodule

// File: rtl/usb_nrzi_tx_checker.sv
module usb_nrzi_tx_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic inReady,
  input logic lineDp,
  input logic lineDm,
  input logic lineOe,
  input logic txActive
);
  // R3: both lines high is never driven
  p_no_se1_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> !(lineDp && lineDm));

  // R6: ready only in a bit-time cycle
  p_ready_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> bitTick);

  // R10: no tick, no line change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable({lineDp, lineDm, lineOe}));

  // R2: the first driven symbol of a packet is K
  p_start_k_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> (!lineDp && lineDm));

  // R7: the driver is released only after a J bit time
  p_release_j_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineOe) |-> ($past(lineDp) && !$past(lineDm)));

  // R9: packet activity tracks the driver enable
  p_active_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    txActive == lineOe);
endmodule

bind usb_nrzi_tx usb_nrzi_tx_checker i_checker (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .inReady(inReady),
  .lineDp(lineDp), .lineDm(lineDm), .lineOe(lineOe), .txActive(txActive)
);

// File: tb/test_usb_nrzi_tx.sv
`timescale 1ns/1ps
module test_usb_nrzi_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady, lineDp, lineDm, lineOe, txActive;

  int checks = 0;
  int errors = 0;

  // symbol codes: 0 idle, 1 J driven, 2 K, 3 SE0
  int expSym[$];
  bit expTake[$];
  int cur = 0;

  always #2.5 clk = ~clk;

  usb_nrzi_tx i_usb_nrzi_tx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .lineDp(lineDp), .lineDm(lineDm), .lineOe(lineOe), .txActive(txActive)
  );

  function automatic int obs();
    if (!lineOe) return (lineDp && !lineDm) ? 0 : 9;
    if (lineDp && !lineDm) return 1;
    if (!lineDp && lineDm) return 2;
    if (!lineDp && !lineDm) return 3;
    return 8;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int mLevel, mOnes;
  task automatic pushBit(input int b, input bit take);
    if (b == 0) mLevel = 1 - mLevel;
    mOnes = b ? mOnes + 1 : 0;
    expSym.push_back(mLevel ? 1 : 2);
    expTake.push_back(take);
  endtask

  task automatic buildModel(input logic [7:0] bytes[$], input bit endFlag);
    mLevel = 1; mOnes = 0;
    for (int i = 0; i < 8; i++) pushBit((i == 7) ? 1 : 0, 1'b0);
    foreach (bytes[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (mOnes == 6) pushBit(0, 1'b0);
        pushBit(int'(bytes[k][i]), i == 0);
      end
    end
    if (mOnes == 6) pushBit(0, 1'b0);
    expSym.push_back(3); expTake.push_back(!endFlag);
    expSym.push_back(3); expTake.push_back(1'b0);
    expSym.push_back(1); expTake.push_back(1'b0);
    expSym.push_back(0); expTake.push_back(1'b0);
  endtask

  task automatic runPacket(input string tag, input logic [7:0] bytes[$],
                           input bit endFlag, input int tickGap);
    int idx = 0;
    int cyc = 0;
    int n = bytes.size();
    buildModel(bytes, endFlag);
    forever begin
      @(negedge clk);
      chk({tag, " R3 line symbol"}, obs(), cur);
      chk({tag, " R9 txActive"}, int'(txActive), int'(cur != 0));
      if (expSym.size() == 0) break;
      bitTick = ((cyc % tickGap) == 0);
      cyc++;
      inValid = (idx < n);
      inData  = (idx < n) ? bytes[idx] : 8'h00;
      inLast  = endFlag && (idx == n - 1);
      #1;
      chk({tag, " R6 inReady"}, int'(inReady), int'(bitTick && expTake[0]));
      if (bitTick) begin
        cur = expSym.pop_front();
        void'(expTake.pop_front());
        if (inReady && inValid) idx++;
      end
    end
    bitTick = 1'b0; inValid = 1'b0; inLast = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 idle line", obs(), 0);
    chk("R1 ready low", int'(inReady), 0);
    chk("R1 active low", int'(txActive), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", obs(), 0);
    // R2 R3 R4: all zeros toggle every bit, preamble seam
    runPacket("zeros", '{8'h00}, 1'b1, 1);
    // R5 R6: long ones runs, ready stalled on stuffed bits
    runPacket("ones", '{8'hFF, 8'hFF, 8'hA5}, 1'b1, 1);
    // R5: preamble trailing one counts toward the run
    runPacket("sync1", '{8'h1F, 8'h3C}, 1'b1, 1);
    // R5 R7: stuffed bit owed before end of packet
    runPacket("tail", '{8'hFC}, 1'b1, 1);
    // R10: sparse ticks, outputs hold between them
    runPacket("sparse", '{8'h5A, 8'hFF}, 1'b1, 3);
    // R8: source stops without the last marker
    runPacket("underrun", '{8'h81, 8'h7E}, 1'b0, 2);
    repeat (4) @(negedge clk);
    chk("R1 idle at end", obs(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule